// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a shared two-wire serial bus back to idle when a target device may be stuck partway through a byte and holding the data line low. A single start pulse launches one recovery run. The block first lets both open-drain lines float high for half a clock period. It then produces a fixed number of clock pulses, nine by default, and notes on every pulse whether the data line was high. It keeps clocking for the full count even after the data line has gone high, so that every target gets back into step.

If the data line was high at least once, the block checks whether both lines read high at that moment. It then forms a START followed directly by a STOP by pulling the data line low and releasing it again. The clock line stays released for this whole pair, so no target ever sees a clock edge between the two conditions. After that it waits out the bus-free time and pulses done. If the data line never went high, the block skips the START/STOP pair and reports failure. After each release of the clock line the block waits for the line to read high, up to a stretch timeout, so a slow target can hold the clock low.

The block drives the lines only through pull-down enables. Its inputs are line levels that have already been synchronized to the clock. While busy it owns both lines.

Top module: `bus_unwedge`

## Requirements
- R1: After synchronous reset, busy, done, fail, not_at_rest, scl_oe and sda_oe are all 0.
- R2: Whenever the block is idle, scl_oe and sda_oe are 0. A start pulse taken while idle makes busy 1 from the next cycle, and both lines then stay released for HALF_CYC cycles before the first clock pulse.
- R3: Each run makes exactly NPULSE clock pulses (scl_oe low-to-high transitions), whatever the data line does. Each pulse holds scl_oe at 1 for HALF_CYC cycles. After the line reads high, the clock stays released for a further HALF_CYC cycles.
- R4: sda_oe stays 0 for the whole clocking phase. sda_in is sampled once per pulse, in the first cycle that scl_in reads 1 after the release. A high sample on any pulse counts as seen.
- R5: After each clock release the block waits for scl_in to be 1. The release phase lasts S+1 cycles when a target holds the line low for S cycles, with S < STRETCH_CYC. If the line stays low for STRETCH_CYC cycles, the block samples the data line and goes on anyway.
- R6: If the data line was never seen high, fail is 1 at done, not_at_rest is 0, and sda_oe is never asserted during the run. Otherwise fail is 0.
- R7: When the data line was seen high, not_at_rest is 1 at done exactly when scl_in or sda_in read 0 in the cycle after the last pulse's high phase.
- R8: On success, scl_oe stays 0 from the last pulse to done. After at least SETUP_CYC cycles of both lines released, sda_oe is 1 for exactly HOLD_CYC cycles. This gives one START and one STOP on an idle bus.
- R9: After sda_oe falls, done comes after exactly BUF_CYC cycles. done is a one-cycle pulse, busy falls with it, and fail and not_at_rest keep their values until the next accepted start.
- R10: A start pulse while busy is ignored: the run still makes NPULSE pulses and one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a recovery run (taken only while idle) |
| scl_in | input | 1 | Synchronized clock-line level |
| sda_in | input | 1 | Synchronized data-line level |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | 1 if the data line was never seen high in the last run |
| not_at_rest | output | 1 | 1 if a line read low just before the START/STOP pair |
| scl_oe | output | 1 | Pull-down enable for the clock line |
| sda_oe | output | 1 | Pull-down enable for the data line |

## Verification
The assertions assume that start is a single-cycle pulse. They also assume that scl_in and sda_in are already synchronized levels of a wired-AND bus, so a line can read high only while its pull-down enable is 0. The bench holds to this by deriving both inputs from a model of that bus. The model combines the block's enables with a target that pulls the data line low on chosen pulses and stretches every clock release by a set number of cycles. Stretches that run past the timeout still leave the clock line able to rise once the target lets go.

// File: rtl/unwedge_pkg.sv
package unwedge_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REL,
        ST_LOW,
        ST_RISE,
        ST_HIGH,
        ST_CHECK,
        ST_SETUP,
        ST_SDAL,
        ST_BUF,
        ST_FIN
    } uw_state_t;

    typedef struct packed {
        logic seen;
        logic fail;
        logic nar;
    } uw_verdict_t;

    function automatic int uw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/unwedge_timer.sv
module unwedge_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/unwedge_pulse_ctr.sv
module unwedge_pulse_ctr #(
    parameter int N = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + CW'(1);
    end

    assign last = (cnt == CW'(N));
endmodule

// File: rtl/bus_unwedge.sv
module bus_unwedge
    import unwedge_pkg::*;
#(
    parameter int HALF_CYC    = 1000,
    parameter int STRETCH_CYC = 200000,
    parameter int SETUP_CYC   = 200,
    parameter int HOLD_CYC    = 200,
    parameter int BUF_CYC     = 12000,
    parameter int NPULSE      = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy,
    output logic done,
    output logic fail,
    output logic not_at_rest,
    output logic scl_oe,
    output logic sda_oe
);
    localparam int TMAX = uw_max(uw_max(HALF_CYC, STRETCH_CYC),
                                 uw_max(uw_max(SETUP_CYC, HOLD_CYC), BUF_CYC));
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] L_HALF    = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] L_STRETCH = TW'(STRETCH_CYC - 1);
    localparam logic [TW-1:0] L_SETUP   = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] L_HOLD    = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] L_BUF     = TW'(BUF_CYC - 1);

    uw_state_t   st, st_nx;
    uw_verdict_t vd, vd_nx;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          p_clr, p_inc, p_last;

    unwedge_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .value(t_val),
        .zero (t_zero)
    );

    unwedge_pulse_ctr #(.N(NPULSE)) u_pulses (
        .clk (clk),
        .rst (rst),
        .clr (p_clr),
        .inc (p_inc),
        .last(p_last)
    );

    always_comb begin
        st_nx  = st;
        vd_nx  = vd;
        t_load = 1'b0;
        t_val  = '0;
        p_clr  = 1'b0;
        p_inc  = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                st_nx  = ST_REL;
                vd_nx  = '0;
                p_clr  = 1'b1;
                t_load = 1'b1;
                t_val  = L_HALF;
            end
            ST_REL: if (t_zero) begin
                st_nx  = ST_LOW;
                t_load = 1'b1;
                t_val  = L_HALF;
            end
            ST_LOW: if (t_zero) begin
                st_nx  = ST_RISE;
                t_load = 1'b1;
                t_val  = L_STRETCH;
            end
            ST_RISE: if (scl_in || t_zero) begin
                vd_nx.seen = vd.seen | sda_in;
                p_inc  = 1'b1;
                st_nx  = ST_HIGH;
                t_load = 1'b1;
                t_val  = L_HALF;
            end
            ST_HIGH: if (t_zero) begin
                if (p_last) begin
                    st_nx = ST_CHECK;
                end else begin
                    st_nx  = ST_LOW;
                    t_load = 1'b1;
                    t_val  = L_HALF;
                end
            end
            ST_CHECK: begin
                if (!vd.seen) begin
                    vd_nx.fail = 1'b1;
                    st_nx      = ST_FIN;
                end else begin
                    vd_nx.nar = !(scl_in && sda_in);
                    st_nx     = ST_SETUP;
                    t_load    = 1'b1;
                    t_val     = L_SETUP;
                end
            end
            ST_SETUP: if (t_zero) begin
                st_nx  = ST_SDAL;
                t_load = 1'b1;
                t_val  = L_HOLD;
            end
            ST_SDAL: if (t_zero) begin
                st_nx  = ST_BUF;
                t_load = 1'b1;
                t_val  = L_BUF;
            end
            ST_BUF: if (t_zero) st_nx = ST_FIN;
            ST_FIN: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            vd <= '0;
        end else begin
            st <= st_nx;
            vd <= vd_nx;
        end
    end

    assign scl_oe      = (st == ST_LOW);
    assign sda_oe      = (st == ST_SDAL);
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_FIN);
    assign fail        = vd.fail;
    assign not_at_rest = vd.nar;
endmodule

// File: rtl/bus_unwedge_chk.sv
module bus_unwedge_chk #(
    parameter int NPULSE = 9
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic fail,
    input logic not_at_rest,
    input logic scl_oe,
    input logic sda_oe
);
    int   lows;
    logic oe_q;
    logic sda_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            lows     <= 0;
            oe_q     <= 1'b0;
            sda_used <= 1'b0;
        end else begin
            oe_q <= scl_oe;
            if (!busy) begin
                lows     <= 0;
                sda_used <= 1'b0;
            end else begin
                if (scl_oe && !oe_q) lows <= lows + 1;
                if (sda_oe) sda_used <= 1'b1;
            end
        end
    end

    // R2
    p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));
    // R3
    p_pulse_count_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (lows == NPULSE));
    // R4
    p_sda_free_clocking_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && lows < NPULSE) |-> !sda_oe);
    // R6
    p_fail_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (!sda_used && !not_at_rest));
    // R8
    p_scl_held_r8: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (!scl_oe && lows == NPULSE));
    // R9
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R10
    p_no_extra_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lows <= NPULSE));
endmodule

bind bus_unwedge bus_unwedge_chk #(.NPULSE(NPULSE)) u_chk (.*);

// File: tb/test_bus_unwedge.sv
`timescale 1ns/1ps
module test_bus_unwedge;
    localparam int H  = 4;
    localparam int ST = 20;
    localparam int SU = 3;
    localparam int HO = 3;
    localparam int BF = 12;
    localparam int NP = 9;

    typedef struct packed {
        logic [8:0] mask;
        logic [7:0] stretch;
        logic       efail;
        logic       enar;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{9'h000, 8'd0,  1'b0, 1'b0},
        '{9'h1FF, 8'd0,  1'b1, 1'b0},
        '{9'h0FF, 8'd0,  1'b0, 1'b0},
        '{9'h1FE, 8'd0,  1'b0, 1'b1},
        '{9'h0F0, 8'd6,  1'b0, 1'b0},
        '{9'h000, 8'd40, 1'b0, 1'b1},
        '{9'h1FF, 8'd6,  1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, fail, not_at_rest, scl_oe, sda_oe;
    logic scl_line, sda_line;

    logic [8:0] mask = '0;
    int   stretch = 0;
    logic run_active = 1'b0;
    logic clr = 1'b0;

    int checks = 0;
    int failures = 0;

    int idx, str_cnt, rises, starts, stops, hold_n, buf_n, done_n;
    int busy_n, early, rel_n, gap;
    logic oe_q, scl_q, sda_q;

    always #2.5 clk = ~clk;

    assign scl_line = !scl_oe && !((str_cnt != 0) || (stretch > 0 && oe_q && !scl_oe));
    assign sda_line = !sda_oe && !(run_active && idx >= 1 && idx <= NP && mask[idx-1]);

    bus_unwedge #(
        .HALF_CYC(H), .STRETCH_CYC(ST), .SETUP_CYC(SU),
        .HOLD_CYC(HO), .BUF_CYC(BF), .NPULSE(NP)
    ) i_bus_unwedge (
        .clk(clk), .rst(rst), .start(start),
        .scl_in(scl_line), .sda_in(sda_line),
        .busy(busy), .done(done), .fail(fail), .not_at_rest(not_at_rest),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(posedge clk) begin
        if (clr) begin
            idx <= 0; str_cnt <= 0; rises <= 0; starts <= 0; stops <= 0;
            hold_n <= 0; buf_n <= 0; done_n <= 0; busy_n <= 0; early <= 0;
            rel_n <= 0; gap <= 0; oe_q <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
        end else begin
            oe_q  <= scl_oe;
            scl_q <= scl_line;
            sda_q <= sda_line;
            if (scl_oe && !oe_q) begin
                idx   <= idx + 1;
                rises <= rises + 1;
            end
            if (!scl_oe && oe_q)
                str_cnt <= (stretch > 0) ? stretch - 1 : 0;
            else if (str_cnt != 0)
                str_cnt <= str_cnt - 1;
            if (scl_line && scl_q && sda_q && !sda_line) starts <= starts + 1;
            if (scl_line && scl_q && !sda_q && sda_line) stops <= stops + 1;
            if (sda_oe) hold_n <= hold_n + 1;
            if (sda_oe && rises < NP) early <= early + 1;
            if (hold_n > 0 && !sda_oe && !done && busy) buf_n <= buf_n + 1;
            if (done) done_n <= done_n + 1;
            if (busy && !done) busy_n <= busy_n + 1;
            if (busy && rises == 0 && !scl_oe) rel_n <= rel_n + 1;
            if (busy && rises == NP && !scl_oe && !sda_oe && hold_n == 0) gap <= gap + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic arm(input logic [8:0] m, input int s);
        @(negedge clk);
        mask = m;
        stretch = s;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        run_active = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        clr = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 fail", fail, 0);
        check("R1 not_at_rest", not_at_rest, 0);
        check("R1 scl_oe/sda_oe", {scl_oe, sda_oe}, 0);

        for (int v = 0; v < NV; v++) begin
            int rise_c, exp_busy;
            arm(VECS[v].mask, int'(VECS[v].stretch));
            wait_done();
            check("R6 fail", fail, VECS[v].efail);
            check("R7 not_at_rest", not_at_rest, VECS[v].enar);
            check("R3 pulse count", rises, NP);
            @(negedge clk);
            check("R9 single done", done_n, 1);
            check("R9 busy after done", busy, 0);
            check("R4 sda released while clocking", early, 0);
            check("R2 release phase", rel_n, H);
            rise_c = (int'(VECS[v].stretch) < ST) ? int'(VECS[v].stretch) + 1 : ST;
            exp_busy = H + NP * (2 * H + rise_c) + 1 + (VECS[v].efail ? 0 : SU + HO + BF);
            check("R5 run length", busy_n, exp_busy);
            if (VECS[v].efail) begin
                check("R6 no sda drive", hold_n, 0);
            end else begin
                check("R8 hold cycles", hold_n, HO);
                check("R9 bus-free cycles", buf_n, BF);
                check("R8 setup at least", (gap >= SU + 1) ? 1 : 0, 1);
                if (!VECS[v].enar) begin
                    check("R8 start count", starts, 1);
                    check("R8 stop count", stops, 1);
                end
            end
            run_active = 1'b0;
            repeat (3) @(negedge clk);
            check("R9 results held", {fail, not_at_rest}, {VECS[v].efail, VECS[v].enar});
        end

        // R10: start while busy is ignored
        arm(9'h000, 0);
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        check("R10 pulse count", rises, NP);
        check("R10 single done", done_n, 1);
        repeat (2) @(negedge clk);
        check("R10 no restart", busy, 0);
        run_active = 1'b0;

        // R9: a new start clears the held failure result
        arm(9'h1FF, 0);
        wait_done();
        check("R9 fail set", fail, 1);
        run_active = 1'b0;
        arm(9'h000, 0);
        check("R9 fail cleared on start", fail, 0);
        wait_done();
        check("R9 success", fail, 0);
        run_active = 1'b0;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule